// File: doc/BRIEF.md
# Self-Routing Butterfly Switch Network

This block moves one wave of up to N packets from N input lanes to N output lanes through a butterfly of log2(N) pipelined columns of 2×2 switches. Each packet carries its destination lane number. Every column looks at exactly one bit of that number and sends the packet to the upper or lower output of its switch. After the last column, a packet that was never turned away sits on the output lane equal to its destination. The first column uses the most significant bit and the last column uses the least significant bit.

A butterfly cannot carry every permutation. Two packets can meet at a switch and want the same output. In that case the packet on the upper input (the lane with the lower index) goes on. The other packet is discarded, and a blocked flag is raised for the input lane it came from. The flags come out together with the delivered packets of the same wave. Each output lane also reports which input lane its packet came from. A new wave can enter on every clock cycle.

Top module: `bfly_net`

## Requirements
- R1: A wave presented on a clock edge appears at the outputs exactly log2(N) edges later. One edge earlier, no output of that wave is visible.
- R2: A packet that is not blocked leaves on the output lane whose index equals its destination, with its payload unchanged and out_src equal to its input lane index.
- R3: The destination is resolved most significant bit first. With N=8, packets from inputs 0 (000) and 4 (100) headed to 1 (001) and 2 (010) collide in the first column. Output 1 gets the packet from input 0, and out_blocked[4] is set.
- R4: At a collision the packet on the lower-index switch input goes on. With N=8, inputs 2 and 3 both headed to 5 collide in the last column. Output 5 carries input 2, and out_blocked[3] is set.
- R5: out_blocked[i] is never set for an input i that had no valid packet. An output lane that receives no packet shows out_valid low.
- R6: For every wave, the number of delivered packets plus the number of blocked flags equals the number of valid input packets.
- R7: While reset is held, and until a wave has crossed the network, out_valid and out_blocked are all zero.
- R8: Waves entered on consecutive cycles do not interact. Each wave's delivery and blocked flags equal what it would produce alone.
- R9: The set of blocked flags is exactly the set predicted by column-by-column routing with upper-input priority. For example, the identity mapping blocks nothing, while bit reversal blocks some packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Packet present on each input lane |
| in_dest | input | N*log2(N) | Destination lane per input, lane i at bits [i*log2(N) +: log2(N)] |
| in_payload | input | N*W | Payload per input, lane i at bits [i*W +: W] |
| out_valid | output | N | Packet delivered on each output lane |
| out_src | output | N*log2(N) | Input lane index of the delivered packet, per output lane |
| out_payload | output | N*W | Delivered payload per output lane |
| out_blocked | output | N | Per input lane: that wave's packet was discarded in a collision |

## Verification
A wrong routing bit or a swapped pair inside one column puts a packet on the wrong output lane, or shows it with the wrong source index, exactly log2(N) cycles after the wave enters. A wrong arbitration decision or a lost blocked flag breaks the balance between delivered packets and blocked flags in that same output cycle. Valid or blocked state that leaks between waves shows up when the next wave leaves, one cycle later. Every wave is compared against a column-by-column conflict model. Two hand-worked collisions fix the bit order and the winner, independently of that model.

// File: rtl/bfly_pkg.sv
`timescale 1ns/1ps
package bfly_pkg;
  // Index of the upper line of switch k in a column that resolves address bit b:
  // a zero is inserted at position b of k.
  function automatic int pair_lo(input int k, input int b);
    return ((k >> b) << (b + 1)) | (k & ((1 << b) - 1));
  endfunction
endpackage

// File: rtl/bfly_sw2.sv
`timescale 1ns/1ps
module bfly_sw2 #(
  parameter int DW = 8
) (
  input  logic          up_v,
  input  logic [DW-1:0] up_d,
  input  logic          up_bit,
  input  logic          dn_v,
  input  logic [DW-1:0] dn_d,
  input  logic          dn_bit,
  output logic          o0_v,
  output logic [DW-1:0] o0_d,
  output logic          o1_v,
  output logic [DW-1:0] o1_d,
  output logic          clash
);
  logic dn_ok;

  always_comb begin
    clash = up_v & dn_v & (up_bit == dn_bit);
    dn_ok = dn_v & ~clash;
    o0_v  = (up_v & ~up_bit) | (dn_ok & ~dn_bit);
    o0_d  = (up_v & ~up_bit) ? up_d : dn_d;
    o1_v  = (up_v & up_bit) | (dn_ok & dn_bit);
    o1_d  = (up_v & up_bit) ? up_d : dn_d;
  end
endmodule

// File: rtl/bfly_stage.sv
`timescale 1ns/1ps
module bfly_stage
  import bfly_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter int STG = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N-1:0]                        in_v,
  input  logic [N-1:0][2*$clog2(N)+W-1:0]     in_d,
  input  logic [N-1:0]                        in_blk,
  output logic [N-1:0]                        out_v,
  output logic [N-1:0][2*$clog2(N)+W-1:0]     out_d,
  output logic [N-1:0]                        out_blk
);
  localparam int S    = $clog2(N);
  localparam int DW   = 2 * S + W;
  localparam int B    = S - 1 - STG;
  localparam int DBIT = W + S + B;
  localparam int NSW  = N / 2;

  logic          v_nxt [N];
  logic [DW-1:0] d_nxt [N];
  logic          clash [NSW];
  logic [S-1:0]  loser [NSW];
  logic [N-1:0]  blk_nxt;

  for (genvar k = 0; k < NSW; k++) begin : g_sw
    localparam int LO = pair_lo(k, B);
    localparam int HI = LO + (1 << B);
    bfly_sw2 #(.DW(DW)) sw_i (
      .up_v  (in_v[LO]),
      .up_d  (in_d[LO]),
      .up_bit(in_d[LO][DBIT]),
      .dn_v  (in_v[HI]),
      .dn_d  (in_d[HI]),
      .dn_bit(in_d[HI][DBIT]),
      .o0_v  (v_nxt[LO]),
      .o0_d  (d_nxt[LO]),
      .o1_v  (v_nxt[HI]),
      .o1_d  (d_nxt[HI]),
      .clash (clash[k])
    );
    assign loser[k] = in_d[HI][W +: S];
  end

  always_comb begin
    blk_nxt = in_blk;
    for (int k = 0; k < NSW; k++) begin
      if (clash[k]) blk_nxt[loser[k]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= '0;
      out_blk <= '0;
    end else begin
      for (int i = 0; i < N; i++) out_v[i] <= v_nxt[i];
      out_blk <= blk_nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (v_nxt[i]) out_d[i] <= d_nxt[i];
    end
  end
endmodule

// File: rtl/bfly_net.sv
`timescale 1ns/1ps
module bfly_net #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             in_valid,
  input  logic [N*$clog2(N)-1:0]   in_dest,
  input  logic [N*W-1:0]           in_payload,
  output logic [N-1:0]             out_valid,
  output logic [N*$clog2(N)-1:0]   out_src,
  output logic [N*W-1:0]           out_payload,
  output logic [N-1:0]             out_blocked
);
  localparam int S  = $clog2(N);
  localparam int DW = 2 * S + W;

  logic rst_s0, rst_s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end

  logic [N-1:0]          v_c [S+1];
  logic [N-1:0][DW-1:0]  d_c [S+1];
  logic [N-1:0]          b_c [S+1];
  logic [N-1:0]          unused_dst;

  assign v_c[0] = in_valid;
  assign b_c[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_lane
    assign d_c[0][k] = {in_dest[k*S +: S], S'(k), in_payload[k*W +: W]};
    assign out_src[k*S +: S]     = d_c[S][k][W +: S];
    assign out_payload[k*W +: W] = d_c[S][k][W-1:0];
    assign unused_dst[k]         = ^d_c[S][k][DW-1:W+S];
  end

  for (genvar s = 0; s < S; s++) begin : g_col
    bfly_stage #(.N(N), .W(W), .STG(s)) stage_i (
      .clk    (clk),
      .rst_n  (rst_s1),
      .in_v   (v_c[s]),
      .in_d   (d_c[s]),
      .in_blk (b_c[s]),
      .out_v  (v_c[s+1]),
      .out_d  (d_c[s+1]),
      .out_blk(b_c[s+1])
    );
  end

  assign out_valid   = v_c[S];
  assign out_blocked = b_c[S];
endmodule

// File: rtl/bfly_net_chk.sv
`timescale 1ns/1ps
module bfly_net_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] in_valid,
  input logic [N-1:0] out_valid,
  input logic [N-1:0] out_blocked
);
  localparam int S = $clog2(N);

  logic [N-1:0] vin_pipe [S];
  logic [N-1:0] vin_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) vin_pipe[i] <= '0;
    end else begin
      vin_pipe[0] <= in_valid;
      for (int i = 1; i < S; i++) vin_pipe[i] <= vin_pipe[i-1];
    end
  end
  assign vin_dly = vin_pipe[S-1];

  // R7: quiet outputs while reset is held
  always @(negedge clk) begin
    if (!rst_n) a_r7_reset_quiet: assert ((out_valid == '0) && (out_blocked == '0));
  end

  // R6: delivered plus blocked equals the valid count of the wave entered S cycles earlier
  a_r6_conservation: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(out_valid) + $countones(out_blocked)) == $countones(vin_dly));

  // R5: blocked flags only for sources that carried a packet
  a_r5_blocked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (out_blocked & ~vin_dly) == '0);

  // R1: a non-empty wave delivers something after exactly S cycles, an empty one nothing
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (|vin_dly) == (|out_valid));

  // R4: input 0 is always the upper switch input, so it is never blocked
  a_r4_src0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    vin_dly[0] |-> !out_blocked[0]);
endmodule

bind bfly_net bfly_net_chk #(.N(N)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_blocked(out_blocked)
);

// File: tb/bfly_net_tb_top.sv
`timescale 1ns/1ps
module bfly_net_tb_top;
  localparam int N = 8;
  localparam int W = 8;
  localparam int S = $clog2(N);

  logic             clk;
  logic             rst_n;
  logic [N-1:0]     in_valid;
  logic [N*S-1:0]   in_dest;
  logic [N*W-1:0]   in_payload;
  logic [N-1:0]     out_valid;
  logic [N*S-1:0]   out_src;
  logic [N*W-1:0]   out_payload;
  logic [N-1:0]     out_blocked;

  int n_tests = 0;
  int n_fail  = 0;

  bfly_net #(.N(N), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_payload(in_payload), .out_valid(out_valid), .out_src(out_src),
    .out_payload(out_payload), .out_blocked(out_blocked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] pay(input int src, input int seed);
    return W'(src * 29 + seed * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Column-by-column conflict model with upper-input priority
  task automatic model(input int dst[N], input logic [N-1:0] vld,
                       output logic [N-1:0] ev, output logic [N-1:0][S-1:0] es,
                       output logic [N-1:0] eb);
    int line[N];
    int nl[N];
    eb = '0;
    for (int i = 0; i < N; i++) line[i] = vld[i] ? i : -1;
    for (int s = 0; s < S; s++) begin
      int b = S - 1 - s;
      for (int i = 0; i < N; i++) nl[i] = -1;
      for (int lo = 0; lo < N; lo++) begin
        if (((lo >> b) & 1) == 0) begin
          int hi = lo | (1 << b);
          int pa = line[lo];
          int pb = line[hi];
          int ta = -1;
          if (pa >= 0) begin
            ta = ((dst[pa] >> b) & 1) ? hi : lo;
            nl[ta] = pa;
          end
          if (pb >= 0) begin
            int tb = ((dst[pb] >> b) & 1) ? hi : lo;
            if (tb == ta) eb[pb] = 1'b1;
            else nl[tb] = pb;
          end
        end
      end
      line = nl;
    end
    for (int i = 0; i < N; i++) begin
      ev[i] = (line[i] >= 0);
      es[i] = ev[i] ? S'(line[i]) : '0;
    end
  endtask

  task automatic drive(input int dst[N], input logic [N-1:0] vld, input int seed);
    in_valid = vld;
    for (int i = 0; i < N; i++) begin
      in_dest[i*S +: S]    = S'(dst[i]);
      in_payload[i*W +: W] = pay(i, seed);
    end
  endtask

  task automatic idle();
    in_valid = '0;
  endtask

  task automatic check_wave(input int dst[N], input logic [N-1:0] vld, input int seed,
                            input string tag);
    logic [N-1:0] ev, eb;
    logic [N-1:0][S-1:0] es;
    model(dst, vld, ev, es, eb);
    for (int d = 0; d < N; d++) begin
      chk(out_valid[d] == ev[d], {tag, " R2 R5 valid"}, out_valid[d], ev[d]);
      if (ev[d] && out_valid[d]) begin
        chk(out_src[d*S +: S] == es[d], {tag, " R2 src"}, out_src[d*S +: S], es[d]);
        chk(out_payload[d*W +: W] == pay(es[d], seed), {tag, " R2 payload"},
            out_payload[d*W +: W], pay(es[d], seed));
      end
    end
    chk(out_blocked == eb, {tag, " R9 blocked"}, out_blocked, eb);
    chk(($countones(out_valid) + $countones(out_blocked)) == $countones(vld),
        {tag, " R6 count"}, $countones(out_valid) + $countones(out_blocked), $countones(vld));
  endtask

  task automatic run_wave(input int dst[N], input logic [N-1:0] vld, input int seed,
                          input string tag);
    @(negedge clk); drive(dst, vld, seed);
    @(posedge clk);
    @(negedge clk); idle();
    repeat (S-1) @(posedge clk);
    @(negedge clk);
    check_wave(dst, vld, seed, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); in_dest = '0; in_payload = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R7 valid in reset", out_valid, 0);
    chk(out_blocked == '0, "R7 blocked in reset", out_blocked, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0 && out_blocked == '0, "R7 idle after reset",
        {out_valid, out_blocked}, 0);
  endtask

  task automatic t_identity();
    int dst[N];
    for (int i = 0; i < N; i++) dst[i] = i;
    run_wave(dst, '1, 1, "identity");
    chk(out_blocked == '0, "R9 identity no block", out_blocked, 0);
  endtask

  task automatic t_bitrev();
    int dst[N];
    for (int i = 0; i < N; i++) begin
      int r = 0;
      for (int b = 0; b < S; b++) r |= ((i >> b) & 1) << (S - 1 - b);
      dst[i] = r;
    end
    run_wave(dst, '1, 2, "bitrev");
    chk(out_blocked != '0, "R9 bitrev blocks", out_blocked, 1);
  endtask

  task automatic t_msb_first();
    int dst[N];
    logic [N-1:0] vld;
    for (int i = 0; i < N; i++) dst[i] = 0;
    dst[0] = 1; dst[4] = 2;
    vld = '0; vld[0] = 1'b1; vld[4] = 1'b1;
    run_wave(dst, vld, 3, "msb");
    chk(out_valid == 8'b0000_0010, "R3 delivered set", out_valid, 8'b0000_0010);
    chk(out_src[1*S +: S] == 0, "R3 winner src", out_src[1*S +: S], 0);
    chk(out_blocked == 8'b0001_0000, "R3 blocked input 4", out_blocked, 8'b0001_0000);
  endtask

  task automatic t_upper_wins();
    int dst[N];
    logic [N-1:0] vld;
    for (int i = 0; i < N; i++) dst[i] = 0;
    dst[2] = 5; dst[3] = 5;
    vld = '0; vld[2] = 1'b1; vld[3] = 1'b1;
    run_wave(dst, vld, 4, "upper");
    chk(out_valid == 8'b0010_0000, "R4 output 5 only", out_valid, 8'b0010_0000);
    chk(out_src[5*S +: S] == 2, "R4 upper wins", out_src[5*S +: S], 2);
    chk(out_blocked == 8'b0000_1000, "R4 input 3 blocked", out_blocked, 8'b0000_1000);
  endtask

  task automatic t_partial();
    int dst[N];
    logic [N-1:0] vld;
    for (int i = 0; i < N; i++) dst[i] = 7;
    vld = 8'b1010_0100;
    run_wave(dst, vld, 5, "partial");
    chk((out_blocked & ~vld) == '0, "R5 no flag for idle inputs", out_blocked & ~vld, 0);
  endtask

  task automatic t_latency();
    int dst[N];
    for (int i = 0; i < N; i++) dst[i] = N - 1 - i;
    @(negedge clk); drive(dst, '1, 6);
    @(posedge clk);
    @(negedge clk); idle();
    repeat (S-2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == '0, "R1 nothing one cycle early", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    check_wave(dst, '1, 6, "latency R1");
  endtask

  task automatic t_back_to_back();
    int da[N];
    int db[N];
    for (int i = 0; i < N; i++) begin da[i] = 0; db[i] = i; end
    @(negedge clk); drive(da, '1, 7);
    @(posedge clk);
    @(negedge clk); drive(db, '1, 8);
    @(posedge clk);
    @(negedge clk); idle();
    repeat (S-2) @(posedge clk);
    @(negedge clk);
    check_wave(da, '1, 7, "b2b first R8");
    @(posedge clk);
    @(negedge clk);
    check_wave(db, '1, 8, "b2b second R8");
    chk(out_blocked == '0, "R8 no leak into second wave", out_blocked, 0);
  endtask

  task automatic t_random(input int count);
    for (int n = 0; n < count; n++) begin
      int p[N];
      for (int i = 0; i < N; i++) p[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j = $urandom_range(i, 0);
        int t = p[i];
        p[i] = p[j]; p[j] = t;
      end
      run_wave(p, '1, 10 + n, "random R9");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_identity();
    t_bitrev();
    t_msb_first();
    t_upper_wins();
    t_partial();
    t_latency();
    t_back_to_back();
    t_random(20);
    repeat (4) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule